// File: doc/BRIEF.md
# USB Host Transfer Fault and Interrupt Controller

This block keeps the fault bookkeeping of a full/low-speed USB host controller. It holds the error countdown of the transfer descriptor being worked on, together with the descriptor's Active and Stalled flags. Each failed transaction lowers the countdown by one. A failure is either a data buffer overrun or underrun, reported by a strobe, or a bit-stuff violation found on the incoming serial stream. When the countdown runs out, the descriptor is retired as stalled.

Beside the countdown it keeps the host status register, the interrupt enable register and the run/stop control bit, and it drives one level-sensitive interrupt line. A transfer error raised by a stall is posted to status only when the current frame ends. A resume seen while the bus is globally suspended is posted at once and can be masked. Two faults are fatal and cannot be masked: a descriptor that fails its sanity check (bad PID or oversized length), and a bus fault reported by the system interface. Either one clears run/stop and halts the controller in the same clock.

Top module: `hc_fault_ctrl`

## Requirements
- R1: A `desc_load` pulse copies `desc_cnt` into the countdown, sets Active and clears Stalled at the next edge. A load in the same cycle as a failure wins, and the count is not changed by anything else.
- R2: A transaction failure while Active with a nonzero count lowers the count by exactly one at the next edge. A buffer fault and a stuff fault in the same cycle count as one failure.
- R3: When `line_vld` is high and `line_bit` is 1 for a seventh consecutive time, the clock after that edge carries a stuff fault, and the count drops one edge later. A valid 0 bit restarts the run. Cycles with `line_vld` low neither extend nor break the run.
- R4: The decrement that brings the count to 0 clears Active and sets Stalled. A descriptor loaded with count 0 never decrements and never stalls.
- R5: Status bit 0 (transfer error) is set only at a `frame_end` pulse. It is set at the first `frame_end` at or after the stall, including a stall in the same cycle as `frame_end`.
- R6: `desc_chk` with a PID other than 8'h69, 8'hE1 or 8'h2D, or with `desc_maxlen` >= 1280, sets status bit 3 (process error) at the next edge. At the same edge it clears run/stop and sets status bit 4 (halted).
- R7: Any bit of `pci_fault` sets status bit 2 (system error) at the next edge, clears run/stop and sets status bit 4.
- R8: `resume_det` sets status bit 1 only while `bus_suspended` is high. Otherwise it has no effect.
- R9: `irq` = (status[0] & enable[0]) | (status[1] & enable[1]) | status[2] | status[3]. Status bits 2 and 3 ignore the enable register.
- R10: Setting `stat_clr_en` with a 1 in `stat_clr[i]` clears status bit i, for i = 0..3. A set in the same cycle wins over the clear. Status bit 4 is not touched by the clear.
- R11: Reset leaves run/stop 0, status 5'b10000 and enable 0. Halted is set at a `frame_end` seen while run/stop is 0. Halted is cleared by writing run/stop to 1. A fatal fault in the same cycle as that write keeps run/stop at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end | input | 1 | One-cycle pulse at the end of a frame |
| desc_load | input | 1 | New descriptor presented |
| desc_cnt | input | CNT_W | Initial error countdown of the new descriptor |
| desc_chk | input | 1 | Descriptor sanity check strobe |
| desc_pid | input | 8 | PID field of the checked descriptor |
| desc_maxlen | input | LEN_W | Length field of the checked descriptor |
| buf_err | input | 1 | Data buffer overrun/underrun strobe |
| line_vld | input | 1 | Incoming serial bit valid |
| line_bit | input | 1 | Incoming serial bit (after line decoding) |
| pci_fault | input | N_BUS_FLT | System bus fault strobes (parity, master abort, target abort) |
| resume_det | input | 1 | Resume signalling detected |
| bus_suspended | input | 1 | Bus is in global suspend |
| stat_clr_en | input | 1 | Write-one-to-clear strobe for status |
| stat_clr | input | 4 | Clear mask for status bits 3..0 |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 2 | Interrupt enable write data |
| run_we | input | 1 | Run/stop write strobe |
| run_wdata | input | 1 | Run/stop write data |
| td_err_cnt | output | CNT_W | Current error countdown |
| td_active | output | 1 | Descriptor Active flag |
| td_stalled | output | 1 | Descriptor Stalled flag |
| hc_status | output | 5 | Status: 0 transfer error, 1 resume, 2 system error, 3 process error, 4 halted |
| hc_ien | output | 2 | Interrupt enables for status bits 0 and 1 |
| hc_run | output | 1 | Run/stop bit |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. In the first, the countdown reaches zero in the cycle that carries `frame_end`, and the status bit must then appear at that same edge. In the second, a status bit is set and cleared in the same cycle, and the set must survive. Both are provoked by directed sequences that line the stall or the fault up with the pulse. Under seeded random stimulus they also recur often, because frame ends, clears and faults are drawn independently. Every cycle is judged against a bench model, built from the requirements, of the count, the flags, the status, the run bit and the interrupt.

// File: rtl/hc_fault_pkg.sv
package hc_fault_pkg;
   // status register layout
   localparam int ST_XFER    = 0;
   localparam int ST_RESUME  = 1;
   localparam int ST_SYSERR  = 2;
   localparam int ST_PROCERR = 3;
   localparam int ST_HALT    = 4;
   localparam int ST_W       = 5;
   localparam int N_STICKY   = 4;   // bits cleared by write-one
   localparam int IE_W       = 2;   // maskable causes

   typedef enum logic [7:0] {
      TOK_OUT   = 8'hE1,
      TOK_IN    = 8'h69,
      TOK_SETUP = 8'h2D
   } tok_pid_e;

   function automatic logic pid_is_token(input logic [7:0] pid);
      return (pid == TOK_OUT) || (pid == TOK_IN) || (pid == TOK_SETUP);
   endfunction
endpackage

// File: rtl/hc_stuff_det.sv
module hc_stuff_det #(
   parameter int MAX_ONES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_vld,
   input  logic line_bit,
   output logic stuff_err
);
   localparam int RUN_W = $clog2(MAX_ONES + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MAX_ONES);

   generate
      if (MAX_ONES < 1) begin : g_bad_max
         $error("hc_stuff_det: MAX_ONES must be at least 1");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;
   logic             hit;

   assign hit = line_vld && line_bit && (run_q == RUN_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= '0;
         stuff_err <= 1'b0;
      end else begin
         stuff_err <= hit;
         if (line_vld) begin
            if (!line_bit || hit) run_q <= '0;
            else                  run_q <= run_q + 1'b1;
         end
      end
   end

   a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_MAX);
   a_r3_seventh_one: assert property (@(posedge clk) disable iff (!rst_n)
      (line_vld && line_bit && run_q == RUN_MAX) |=> stuff_err);
   a_r3_zero_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (line_vld && !line_bit) |=> (run_q == '0) && !stuff_err);
endmodule

// File: rtl/hc_td_errcnt.sv
module hc_td_errcnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             desc_load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             xact_err,
   output logic [CNT_W-1:0] cnt,
   output logic             active,
   output logic             stalled,
   output logic             stall_evt
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("hc_td_errcnt: CNT_W must be at least 1");
      end
   endgenerate

   logic dec_ok;

   assign dec_ok    = xact_err && active && (cnt != '0) && !desc_load;
   assign stall_evt = dec_ok && (cnt == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         active  <= 1'b0;
         stalled <= 1'b0;
      end else if (desc_load) begin
         cnt     <= load_cnt;
         active  <= 1'b1;
         stalled <= 1'b0;
      end else if (dec_ok) begin
         cnt <= cnt - 1'b1;
         if (cnt == CNT_ONE) begin
            active  <= 1'b0;
            stalled <= 1'b1;
         end
      end
   end

   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      desc_load |=> active && !stalled && (cnt == $past(load_cnt)));
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!desc_load && !xact_err) |=> $stable(cnt));
   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!desc_load && xact_err && active && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
   a_r4_zero_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (!desc_load && cnt == '0 && active) |=> active && !stalled && cnt == '0);
   a_r4_stall_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (!desc_load && $fell(active)) |-> stalled && cnt == '0);
endmodule

// File: rtl/hc_td_check.sv
module hc_td_check #(
   parameter int LEN_W     = 11,
   parameter int LEN_LIMIT = 1280
) (
   input  logic             desc_chk,
   input  logic [7:0]       desc_pid,
   input  logic [LEN_W-1:0] desc_maxlen,
   output logic             proc_evt
);
   import hc_fault_pkg::*;

   localparam logic [LEN_W:0] LIMIT_V = (LEN_W+1)'(LEN_LIMIT);

   generate
      if (LEN_LIMIT < 1 || LEN_LIMIT > (1 << LEN_W)) begin : g_bad_limit
         $error("hc_td_check: LEN_LIMIT must lie in 1 .. 2**LEN_W");
      end
   endgenerate

   logic pid_bad;
   logic len_bad;

   always_comb begin
      pid_bad  = !pid_is_token(desc_pid);
      len_bad  = {1'b0, desc_maxlen} >= LIMIT_V;
      proc_evt = desc_chk && (pid_bad || len_bad);
   end
endmodule

// File: rtl/hc_status_ctl.sv
module hc_status_ctl
   import hc_fault_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_end,
   input  logic                stall_evt,
   input  logic                resume_evt,
   input  logic                sys_evt,
   input  logic                proc_evt,
   input  logic                clr_en,
   input  logic [N_STICKY-1:0] clr_mask,
   input  logic                ien_we,
   input  logic [IE_W-1:0]     ien_wdata,
   input  logic                run_we,
   input  logic                run_wdata,
   output logic [ST_W-1:0]     status,
   output logic [IE_W-1:0]     ien,
   output logic                run_stop,
   output logic                irq
);
   logic                fatal;
   logic                pend_q;
   logic [N_STICKY-1:0] set_vec;
   logic [N_STICKY-1:0] sticky_q;
   logic                halt_q;

   assign fatal = sys_evt || proc_evt;

   always_comb begin
      set_vec             = '0;
      set_vec[ST_XFER]    = frame_end && (pend_q || stall_evt);
      set_vec[ST_RESUME]  = resume_evt;
      set_vec[ST_SYSERR]  = sys_evt;
      set_vec[ST_PROCERR] = proc_evt;
   end

   // a stall waits here for the end of its frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q || stall_evt) && !frame_end;
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_STICKY; gi++) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               sticky_q[gi] <= 1'b0;
            else if (set_vec[gi])     sticky_q[gi] <= 1'b1;
            else if (clr_en && clr_mask[gi]) sticky_q[gi] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_stop <= 1'b0;
         halt_q   <= 1'b1;
         ien      <= '0;
      end else begin
         if (ien_we) ien <= ien_wdata;
         if (fatal) begin
            run_stop <= 1'b0;
            halt_q   <= 1'b1;
         end else if (run_we) begin
            run_stop <= run_wdata;
            if (run_wdata)                  halt_q <= 1'b0;
            else if (frame_end && !run_stop) halt_q <= 1'b1;
         end else if (frame_end && !run_stop) begin
            halt_q <= 1'b1;
         end
      end
   end

   assign status = {halt_q, sticky_q};
   assign irq    = |(sticky_q[IE_W-1:0] & ien) | sticky_q[ST_SYSERR] | sticky_q[ST_PROCERR];

   a_r5_xfer_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_XFER]) |-> $past(frame_end));
   a_r5_stall_posted: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && stall_evt) |=> status[ST_XFER]);
   a_r6_proc_halts: assert property (@(posedge clk) disable iff (!rst_n)
      proc_evt |=> !run_stop && status[ST_HALT] && status[ST_PROCERR]);
   a_r7_sys_halts: assert property (@(posedge clk) disable iff (!rst_n)
      sys_evt |=> !run_stop && status[ST_HALT] && status[ST_SYSERR]);
   a_r8_resume_posted: assert property (@(posedge clk) disable iff (!rst_n)
      resume_evt |=> status[ST_RESUME]);
   a_r9_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_SYSERR] || status[ST_PROCERR]) |-> irq);
   a_r10_clear_proc: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_mask[ST_PROCERR] && !proc_evt) |=> !status[ST_PROCERR]);
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_mask[ST_SYSERR] && sys_evt) |=> status[ST_SYSERR]);
   a_r11_halt_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !run_stop && !(run_we && run_wdata)) |=> status[ST_HALT]);
   a_r11_fatal_beats_run: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal && run_we && run_wdata) |=> !run_stop);
endmodule

// File: rtl/hc_fault_ctrl.sv
module hc_fault_ctrl
   import hc_fault_pkg::*;
#(
   parameter int CNT_W     = 2,
   parameter int LEN_W     = 11,
   parameter int LEN_LIMIT = 1280,
   parameter int MAX_ONES  = 6,
   parameter int N_BUS_FLT = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_end,
   input  logic                 desc_load,
   input  logic [CNT_W-1:0]     desc_cnt,
   input  logic                 desc_chk,
   input  logic [7:0]           desc_pid,
   input  logic [LEN_W-1:0]     desc_maxlen,
   input  logic                 buf_err,
   input  logic                 line_vld,
   input  logic                 line_bit,
   input  logic [N_BUS_FLT-1:0] pci_fault,
   input  logic                 resume_det,
   input  logic                 bus_suspended,
   input  logic                 stat_clr_en,
   input  logic [N_STICKY-1:0]  stat_clr,
   input  logic                 ien_we,
   input  logic [IE_W-1:0]      ien_wdata,
   input  logic                 run_we,
   input  logic                 run_wdata,
   output logic [CNT_W-1:0]     td_err_cnt,
   output logic                 td_active,
   output logic                 td_stalled,
   output logic [ST_W-1:0]      hc_status,
   output logic [IE_W-1:0]      hc_ien,
   output logic                 hc_run,
   output logic                 irq
);
   generate
      if (N_BUS_FLT < 1) begin : g_bad_flt
         $error("hc_fault_ctrl: N_BUS_FLT must be at least 1");
      end
   endgenerate

   logic stuff_err;
   logic xact_err;
   logic stall_evt;
   logic proc_evt;
   logic sys_evt;
   logic resume_evt;

   assign xact_err   = buf_err || stuff_err;
   assign sys_evt    = |pci_fault;
   assign resume_evt = resume_det && bus_suspended;

   hc_stuff_det #(.MAX_ONES(MAX_ONES)) u_stuff (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_vld (line_vld),
      .line_bit (line_bit),
      .stuff_err(stuff_err)
   );

   hc_td_errcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .desc_load(desc_load),
      .load_cnt (desc_cnt),
      .xact_err (xact_err),
      .cnt      (td_err_cnt),
      .active   (td_active),
      .stalled  (td_stalled),
      .stall_evt(stall_evt)
   );

   hc_td_check #(.LEN_W(LEN_W), .LEN_LIMIT(LEN_LIMIT)) u_chk (
      .desc_chk   (desc_chk),
      .desc_pid   (desc_pid),
      .desc_maxlen(desc_maxlen),
      .proc_evt   (proc_evt)
   );

   hc_status_ctl u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .stall_evt (stall_evt),
      .resume_evt(resume_evt),
      .sys_evt   (sys_evt),
      .proc_evt  (proc_evt),
      .clr_en    (stat_clr_en),
      .clr_mask  (stat_clr),
      .ien_we    (ien_we),
      .ien_wdata (ien_wdata),
      .run_we    (run_we),
      .run_wdata (run_wdata),
      .status    (hc_status),
      .ien       (hc_ien),
      .run_stop  (hc_run),
      .irq       (irq)
   );

   a_r6_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_chk && {1'b0, desc_maxlen} >= (LEN_W+1)'(LEN_LIMIT)) |=> hc_status[ST_PROCERR] && !hc_run);
   a_r8_resume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!resume_det || !bus_suspended) && !hc_status[ST_RESUME] |=> !hc_status[ST_RESUME]);
endmodule

// File: tb/hc_fault_ctrl_tb.sv
module hc_fault_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_end = 0, desc_load = 0, desc_chk = 0, buf_err = 0;
   logic [1:0] desc_cnt = 0;
   logic [7:0] desc_pid = 0;
   logic [10:0] desc_maxlen = 0;
   logic       line_vld = 0, line_bit = 0;
   logic [2:0] pci_fault = 0;
   logic       resume_det = 0, bus_suspended = 0;
   logic       stat_clr_en = 0;
   logic [3:0] stat_clr = 0;
   logic       ien_we = 0;
   logic [1:0] ien_wdata = 0;
   logic       run_we = 0, run_wdata = 0;
   logic [1:0] td_err_cnt;
   logic       td_active, td_stalled, hc_run, irq;
   logic [4:0] hc_status;
   logic [1:0] hc_ien;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   hc_fault_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .desc_load(desc_load),
      .desc_cnt(desc_cnt), .desc_chk(desc_chk), .desc_pid(desc_pid),
      .desc_maxlen(desc_maxlen), .buf_err(buf_err), .line_vld(line_vld),
      .line_bit(line_bit), .pci_fault(pci_fault), .resume_det(resume_det),
      .bus_suspended(bus_suspended), .stat_clr_en(stat_clr_en), .stat_clr(stat_clr),
      .ien_we(ien_we), .ien_wdata(ien_wdata), .run_we(run_we), .run_wdata(run_wdata),
      .td_err_cnt(td_err_cnt), .td_active(td_active), .td_stalled(td_stalled),
      .hc_status(hc_status), .hc_ien(hc_ien), .hc_run(hc_run), .irq(irq)
   );

   // ---------------- reference model built from the requirements
   logic [1:0] m_cnt;
   logic       m_act, m_stl, m_pend, m_run, m_sq;
   logic [4:0] m_stat;
   logic [1:0] m_ien;
   int         m_srun;

   function automatic logic pid_ok(input logic [7:0] p);
      return p == 8'h69 || p == 8'hE1 || p == 8'h2D;
   endfunction

   function automatic logic exp_irq(input logic [4:0] s, input logic [1:0] e);
      return (s[0] & e[0]) | (s[1] & e[1]) | s[2] | s[3];
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_act = 0; m_stl = 0; m_pend = 0; m_run = 0; m_sq = 0;
      m_stat = 5'b10000; m_ien = 0; m_srun = 0;
   endtask

   task automatic model_update();
      logic err, stall, proc, sys, res, nsq;
      logic [3:0] setv;
      err = buf_err | m_sq; stall = 0;
      nsq = 0;
      if (line_vld) begin
         if (line_bit) begin
            if (m_srun == 6) begin nsq = 1; m_srun = 0; end
            else m_srun = m_srun + 1;
         end else m_srun = 0;
      end
      m_sq = nsq;
      if (desc_load) begin m_cnt = desc_cnt; m_act = 1; m_stl = 0; end
      else if (err && m_act && m_cnt != 0) begin
         m_cnt = m_cnt - 1;
         if (m_cnt == 0) begin m_act = 0; m_stl = 1; stall = 1; end
      end
      proc = desc_chk && (!pid_ok(desc_pid) || desc_maxlen >= 11'd1280);
      sys  = |pci_fault;
      res  = resume_det && bus_suspended;
      setv = {proc, sys, res, frame_end && (m_pend || stall)};
      m_pend = (m_pend || stall) && !frame_end;
      for (int i = 0; i < 4; i++)
         m_stat[i] = setv[i] | (m_stat[i] & ~(stat_clr_en & stat_clr[i]));
      if (ien_we) m_ien = ien_wdata;
      if (proc || sys) begin m_run = 0; m_stat[4] = 1; end
      else if (run_we && run_wdata) begin m_run = 1; m_stat[4] = 0; end
      else begin
         if (frame_end && !m_run) m_stat[4] = 1;
         if (run_we) m_run = 0;
      end
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R2 count", td_err_cnt, m_cnt);
      check("R4 active", td_active, m_act);
      check("R4 stalled", td_stalled, m_stl);
      check("R10 status", hc_status, m_stat);
      check("R9 enable", hc_ien, m_ien);
      check("R11 run", hc_run, m_run);
      check("R9 irq", irq, exp_irq(m_stat, m_ien));
   endtask

   task automatic idle();
      frame_end = 0; desc_load = 0; desc_chk = 0; buf_err = 0; line_vld = 0;
      pci_fault = 0; resume_det = 0; stat_clr_en = 0; stat_clr = 0;
      ien_we = 0; run_we = 0;
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_all();
      idle();
   endtask

   task automatic send_bit(input logic b);
      line_vld = 1; line_bit = b; step();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240613));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // r11_ reset state
      check("R11 reset status", hc_status, 5'b10000);
      check("R11 reset run", hc_run, 0);
      check("R9 reset irq", irq, 0);
      compare_all();

      ien_we = 1; ien_wdata = 2'b11; run_we = 1; run_wdata = 1; step();
      check("R11 run clears halt", hc_status[4], 0);

      desc_load = 1; desc_cnt = 3; step();
      check("R1 load count", td_err_cnt, 3);
      check("R1 load active", td_active, 1);

      buf_err = 1; step();
      check("R2 buffer decrement", td_err_cnt, 2);

      // six ones, a zero, six ones: no stuff fault (R3)
      for (int i = 0; i < 6; i++) send_bit(1);
      line_vld = 0; step();  // idle cycle does not break the run
      send_bit(0);
      for (int i = 0; i < 6; i++) send_bit(1);
      step(); step();
      check("R3 no fault below limit", td_err_cnt, 2);
      send_bit(1);            // seventh consecutive one
      check("R3 not yet counted", td_err_cnt, 2);
      step();
      check("R3 stuff decrement", td_err_cnt, 1);

      buf_err = 1; step();
      check("R4 stall count", td_err_cnt, 0);
      check("R4 stalled flag", td_stalled, 1);
      check("R5 not before frame end", hc_status[0], 0);
      step();
      check("R5 still waiting", hc_status[0], 0);
      frame_end = 1; step();
      check("R5 posted at frame end", hc_status[0], 1);
      check("R9 transfer irq", irq, 1);

      stat_clr_en = 1; stat_clr = 4'b0001; step();
      check("R10 clear transfer", hc_status[0], 0);

      desc_load = 1; desc_cnt = 0; step();
      buf_err = 1; step();
      check("R4 zero count no stall", {td_active, td_stalled, td_err_cnt}, 4'b1000);

      // stall in the same cycle as frame end (R5)
      desc_load = 1; desc_cnt = 1; step();
      buf_err = 1; frame_end = 1; step();
      check("R5 same-cycle stall", hc_status[0], 1);
      stat_clr_en = 1; stat_clr = 4'b0001; step();

      resume_det = 1; bus_suspended = 0; step();
      check("R8 resume ignored", hc_status[1], 0);
      resume_det = 1; bus_suspended = 1; step();
      check("R8 resume posted", hc_status[1], 1);
      ien_we = 1; ien_wdata = 2'b00; step();
      check("R9 resume masked", irq, 0);
      stat_clr_en = 1; stat_clr = 4'b0010; step();

      desc_chk = 1; desc_pid = 8'h69; desc_maxlen = 11'd1279; step();
      check("R6 good descriptor", hc_status[3], 0);
      desc_chk = 1; desc_pid = 8'hE1; desc_maxlen = 11'd1280; step();
      check("R6 length fault", hc_status[3], 1);
      check("R6 run cleared", hc_run, 0);
      check("R9 process irq unmasked", irq, 1);
      stat_clr_en = 1; stat_clr = 4'b1000; run_we = 1; run_wdata = 1; step();
      desc_chk = 1; desc_pid = 8'h5A; desc_maxlen = 11'd8; step();
      check("R6 pid fault", hc_status[4:3], 2'b11);

      stat_clr_en = 1; stat_clr = 4'b1000; run_we = 1; run_wdata = 1; step();
      pci_fault = 3'b010; run_we = 1; run_wdata = 1; stat_clr_en = 1; stat_clr = 4'b0100; step();
      check("R7 system fault", hc_status[2], 1);
      check("R11 fault beats run write", hc_run, 0);
      check("R10 set beats clear", hc_status[2], 1);

      stat_clr_en = 1; stat_clr = 4'b1111; step();
      check("R10 halt not cleared", hc_status[4], 1);
      run_we = 1; run_wdata = 1; step();
      run_we = 1; run_wdata = 0; step();
      check("R11 halt waits for frame", hc_status[4], 0);
      frame_end = 1; step();
      check("R11 halt at frame end", hc_status[4], 1);

      // seeded random phase, every cycle judged against the model
      for (int n = 0; n < 4000; n++) begin
         frame_end   = ($urandom % 12) == 0;
         desc_load   = ($urandom % 24) == 0;
         desc_cnt    = 2'($urandom);
         buf_err     = ($urandom % 6) == 0;
         line_vld    = ($urandom % 4) != 0;
         line_bit    = ($urandom % 10) != 0;
         desc_chk    = ($urandom % 20) == 0;
         desc_pid    = (($urandom % 4) == 0) ? 8'($urandom) : 8'h2D;
         desc_maxlen = 11'(1200 + ($urandom % 120));
         pci_fault   = (($urandom % 80) == 0) ? 3'(1 << ($urandom % 3)) : 3'b000;
         resume_det  = ($urandom % 16) == 0;
         bus_suspended = ($urandom % 2) == 0;
         stat_clr_en = ($urandom % 8) == 0;
         stat_clr    = 4'($urandom);
         ien_we      = ($urandom % 32) == 0;
         ien_wdata   = 2'($urandom);
         run_we      = ($urandom % 10) == 0;
         run_wdata   = ($urandom % 4) != 0;
         step();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule